// File: doc/BRIEF.md
# Six-Switch Inverter SPWM Gate Generator

This block drives the six gate enables of a single-phase full bridge that carries two extra switches on its DC side. The bridge switches are S1/S2 (leg A, upper/lower) and S3/S4 (leg B, upper/lower). S5 and S6 are the DC-side switches. The block runs a triangular carrier from 0 up to a programmable top count and back down. At each carrier peak it latches the sign and the clamped magnitude of a signed reference sample, and it latches the mode. It then compares the latched values with the carrier to decide what each leg wants. Two mode options exist: unipolar SPWM, where one leg is parked for a whole half cycle, and double-frequency SPWM, where the two legs follow references of opposite sign.

Each leg passes through a dead-band state machine. Its states are `DB_OFF` (hold), `DB_LOW`, `DB_HIGH` and `DB_GAP`. The transitions are: hold to `DB_OFF`; off-exit straight to the wanted side; low or high to gap on a change of request; gap-expiry to the side requested at that moment. This machine guarantees that a switch and its complement are never on together. The DC-side switches copy bridge switches chosen by the latched polarity, so they move in exact lockstep with their partners.

A start-up sequencer holds all gates low. Its states are `PH_PRIME`, `PH_SETTLE` and `PH_DRIVE`. It moves from prime to settle at the first peak after reset, and from settle to drive at the second. The gates stay off until one full carrier period of latched data exists.

Top module: `hb6_spwm_gen`

## Requirements
- R1: gate_on bit i drives switch S(i+1). In unipolar mode with a non-negative latched reference, S1 and S6 stay on for the whole period. S4 and S5 switch with identical timing. The request for S4 is high when the magnitude exceeds the carrier count, or when the magnitude is at least the top count.
- R2: In unipolar mode with a negative latched reference, S2 and S5 stay on. S3 and S6 switch with identical timing, using the same comparison as R1.
- R3: S1 and S2 are never on in the same cycle, and neither are S3 and S4. Apart from dead time, S2 is the complement of S1 and S4 is the complement of S3.
- R4: On every change of a leg's request, both switches of that leg are off for max(D,1) cycles, where D is dead_cycles, before the new side turns on.
- R5: In double-frequency mode, with signed clamped reference s, the request for S1 is high when 2s+top > 2·count. The request for S3 is high when top−2s > 2·count. For a non-negative reference, S6 follows S1 and S5 follows S4. For a negative reference, S5 follows S2 and S6 follows S3.
- R6: The carrier counts 0 up to carrier_top and back to 0, with a period of 2·carrier_top cycles (carrier_top ≥ 2). peak_strobe is high for one cycle when the count reaches carrier_top while rising; this first happens carrier_top cycles after reset release.
- R7: Polarity, magnitude and mode are latched only on the clock edge that ends a peak_strobe cycle. Changes in the middle of a period do not move any gate until the next peak.
- R8: All gates are low while rst is high. After release they stay low until the second peak has been taken; the first gate turns on 3·carrier_top+2 cycles after release.
- R9: A reference magnitude above carrier_top is clamped to carrier_top, so the switching leg stays in a continuous on or off state instead of pulsing.
- R10: A zero reference counts as the positive half cycle. In unipolar mode this gives the zero state: S1, S3 and S6 are on, while S2, S4 and S5 are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_sample | input | REF_W | Signed reference sample |
| carrier_top | input | CNT_W | Carrier peak count (half period in cycles) |
| dbl_mode | input | 1 | 0 = unipolar, 1 = double-frequency |
| dead_cycles | input | DT_W | Dead time in clock cycles |
| gate_on | output | 6 | Gate enables, bit 0 = S1 … bit 5 = S6 |
| peak_strobe | output | 1 | One-cycle pulse at each carrier peak |

## Verification
A leg request derived from the carrier count reaches the gates one clock later, through the registered dead-band state. A reference change takes effect on the edge after the strobe. The first gate appears exactly 3·carrier_top+2 edges after reset release, and the bench counts edges from the release to sample that cycle and the one before it. Duty results are checked as on-cycle counts over a full 2·carrier_top window. The window starts after three peaks have passed, so latching and dead-band transients are over and the count does not depend on where the window starts. Lockstep and exclusivity are checked every cycle of that window, and all sampling happens on the falling clock edge.

// File: rtl/hb6_pkg.sv
package hb6_pkg;

    typedef enum logic [1:0] {
        PH_PRIME,
        PH_SETTLE,
        PH_DRIVE
    } phase_t;

    typedef enum logic [1:0] {
        DB_OFF,
        DB_LOW,
        DB_HIGH,
        DB_GAP
    } db_state_t;

endpackage

// File: rtl/hb6_carrier.sv
module hb6_carrier #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] carrier_top,
    output logic [CNT_W-1:0] count,
    output logic             peak
);
    logic rising_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            rising_q <= 1'b1;
        end else if (rising_q) begin
            if (count >= carrier_top) begin
                rising_q <= 1'b0;
                count    <= count - 1'b1;
            end else begin
                count    <= count + 1'b1;
            end
        end else begin
            if (count == '0) begin
                rising_q <= 1'b1;
                count    <= count + 1'b1;
            end else begin
                count    <= count - 1'b1;
            end
        end
    end

    assign peak = rising_q && (count >= carrier_top) && !rst;
endmodule

// File: rtl/hb6_targets.sv
module hb6_targets #(
    parameter int CNT_W = 12,
    parameter int REF_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    peak,
    input  logic signed [REF_W-1:0] ref_sample,
    input  logic [CNT_W-1:0]        carrier_top,
    input  logic [CNT_W-1:0]        count,
    input  logic                    dbl_mode,
    output logic                    want_a,
    output logic                    want_b,
    output logic                    pol_neg
);
    localparam int MW = (REF_W + 1 > CNT_W) ? REF_W + 1 : CNT_W;
    localparam int SW = CNT_W + 3;

    logic                   dbl_q;
    logic [CNT_W-1:0]       mag_q;
    logic signed [REF_W:0]  ref_ext;
    logic [MW-1:0]          abs_w;
    logic [MW-1:0]          top_w;
    logic [CNT_W-1:0]       mag_next;

    always_comb begin
        ref_ext  = (REF_W + 1)'(ref_sample);
        abs_w    = ref_ext[REF_W] ? MW'(-ref_ext) : MW'(ref_ext);
        top_w    = MW'(carrier_top);
        mag_next = (abs_w > top_w) ? carrier_top : abs_w[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_neg <= 1'b0;
            mag_q   <= '0;
            dbl_q   <= 1'b0;
        end else if (peak) begin
            pol_neg <= ref_sample[REF_W-1];
            mag_q   <= mag_next;
            dbl_q   <= dbl_mode;
        end
    end

    logic signed [SW-1:0] s_ref, twice_cnt, top_s, xa, xb;
    logic                 uni_pwm;

    always_comb begin
        top_s     = $signed({3'b000, carrier_top});
        s_ref     = pol_neg ? -$signed({3'b000, mag_q}) : $signed({3'b000, mag_q});
        twice_cnt = $signed({2'b00, count, 1'b0});
        xa        = (s_ref <<< 1) + top_s;
        xb        = top_s - (s_ref <<< 1);
        uni_pwm   = (mag_q >= carrier_top) || (mag_q > count);
        if (dbl_q) begin
            want_a = xa > twice_cnt;
            want_b = xb > twice_cnt;
        end else begin
            want_a = !pol_neg;
            want_b = pol_neg ? uni_pwm : !uni_pwm;
        end
    end
endmodule

// File: rtl/hb6_deadband.sv
module hb6_deadband
    import hb6_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    input  logic            want_hi,
    input  logic [DT_W-1:0] dead,
    output logic            out_hi,
    output logic            out_lo
);
    db_state_t       state_q, state_d;
    logic [DT_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst) state_q <= DB_OFF;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DB_OFF:  if (!hold) state_d = want_hi ? DB_HIGH : DB_LOW;
            DB_LOW:  if (hold) state_d = DB_OFF;
                     else if (want_hi) state_d = DB_GAP;
            DB_HIGH: if (hold) state_d = DB_OFF;
                     else if (!want_hi) state_d = DB_GAP;
            DB_GAP:  if (hold) state_d = DB_OFF;
                     else if (gap_q <= DT_W'(1)) state_d = want_hi ? DB_HIGH : DB_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                                      gap_q <= '0;
        else if (state_q != DB_GAP && state_d == DB_GAP) gap_q <= dead;
        else if (state_q == DB_GAP && gap_q != '0)   gap_q <= gap_q - 1'b1;
    end

    always_comb begin
        out_hi = (state_q == DB_HIGH);
        out_lo = (state_q == DB_LOW);
    end
endmodule

// File: rtl/hb6_spwm_gen.sv
module hb6_spwm_gen
    import hb6_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int REF_W = 16,
    parameter int DT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [REF_W-1:0] ref_sample,
    input  logic [CNT_W-1:0]        carrier_top,
    input  logic                    dbl_mode,
    input  logic [DT_W-1:0]         dead_cycles,
    output logic [5:0]              gate_on,
    output logic                    peak_strobe
);
    localparam int NUM_LEGS = 2;

    phase_t               phase_q, phase_d;
    logic                 hold, pol_neg;
    logic [CNT_W-1:0]     count;
    logic [NUM_LEGS-1:0]  want, leg_hi, leg_lo;

    hb6_carrier #(.CNT_W(CNT_W)) u_carrier (
        .clk(clk), .rst(rst), .carrier_top(carrier_top),
        .count(count), .peak(peak_strobe)
    );

    hb6_targets #(.CNT_W(CNT_W), .REF_W(REF_W)) u_targets (
        .clk(clk), .rst(rst), .peak(peak_strobe), .ref_sample(ref_sample),
        .carrier_top(carrier_top), .count(count), .dbl_mode(dbl_mode),
        .want_a(want[0]), .want_b(want[1]), .pol_neg(pol_neg)
    );

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_PRIME;
        else     phase_q <= phase_d;
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_PRIME:  if (peak_strobe) phase_d = PH_SETTLE;
            PH_SETTLE: if (peak_strobe) phase_d = PH_DRIVE;
            PH_DRIVE:  phase_d = PH_DRIVE;
        endcase
    end

    always_comb hold = (phase_q != PH_DRIVE);

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hb6_deadband #(.DT_W(DT_W)) u_db (
            .clk(clk), .rst(rst), .hold(hold), .want_hi(want[g]),
            .dead(dead_cycles), .out_hi(leg_hi[g]), .out_lo(leg_lo[g])
        );
    end

    always_comb begin
        gate_on[0] = leg_hi[0];
        gate_on[1] = leg_lo[0];
        gate_on[2] = leg_hi[1];
        gate_on[3] = leg_lo[1];
        gate_on[4] = pol_neg ? leg_lo[0] : leg_lo[1];
        gate_on[5] = pol_neg ? leg_hi[1] : leg_hi[0];
    end
endmodule

// File: rtl/hb6_spwm_gen_checks.sv
module hb6_spwm_gen_checks
    import hb6_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [5:0] gate_on,
    input logic       peak_strobe,
    input phase_t     phase,
    input logic       pol_neg
);
    // R3: leg A switches never overlap
    a_r3_leg_a_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(gate_on[0] && gate_on[1]));

    // R3: leg B switches never overlap
    a_r3_leg_b_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(gate_on[2] && gate_on[3]));

    // R8: no gate while the start-up sequencer has not reached drive
    a_r8_hold_until_drive: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_DRIVE) |-> (gate_on == 6'b0));

    // R6: peak strobe lasts a single cycle
    a_r6_single_peak: assert property (@(posedge clk) disable iff (rst)
        peak_strobe |=> !peak_strobe);

    // R7: latched polarity only moves after a peak
    a_r7_polarity_latched: assert property (@(posedge clk) disable iff (rst)
        !$past(peak_strobe) |-> $stable(pol_neg));
endmodule

bind hb6_spwm_gen hb6_spwm_gen_checks u_checks (
    .clk(clk), .rst(rst), .gate_on(gate_on), .peak_strobe(peak_strobe),
    .phase(phase_q), .pol_neg(pol_neg)
);

// File: tb/hb6_spwm_gen_test.sv
module hb6_spwm_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int TOP        = 20;
    localparam int PER        = 2 * TOP;
    localparam int NV         = 8;

    // columns: dbl, ref, dead, on-counts of S1..S6 over one period
    localparam int VEC [0:NV-1][0:8] = '{
        '{0,    8, 2, 40,  0, 23, 13, 13, 40},
        '{0,  -12, 2,  0, 40, 21, 15, 40, 21},
        '{0,  100, 2, 40,  0,  0, 40, 40, 40},
        '{1,    5, 2, 27,  9,  7, 29, 29, 27},
        '{1,   -5, 2,  7, 29, 27,  9, 29, 27},
        '{0,    8, 0, 40,  0, 24, 14, 14, 40},
        '{1, -100, 2,  0, 40, 40,  0, 40, 40},
        '{0,    0, 2, 40,  0, 40,  0,  0, 40}
    };
    localparam string TAGS [0:NV-1] = '{"R1", "R2", "R9", "R5", "R5", "R4", "R9", "R10"};

    logic               clk = 1'b0;
    logic               rst;
    logic signed [15:0] ref_sample;
    logic [11:0]        carrier_top;
    logic               dbl_mode;
    logic [7:0]         dead_cycles;
    logic [5:0]         gate_on;
    logic               peak_strobe;

    int errors = 0;
    int checks = 0;

    hb6_spwm_gen uut (
        .clk(clk), .rst(rst), .ref_sample(ref_sample), .carrier_top(carrier_top),
        .dbl_mode(dbl_mode), .dead_cycles(dead_cycles),
        .gate_on(gate_on), .peak_strobe(peak_strobe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic wait_peak();
        do @(negedge clk); while (!peak_strobe);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int nz;
        int first_pk;
        int n;
        bit ok;
        rst         = 1'b1;
        ref_sample  = 16'sd8;
        carrier_top = 12'(TOP);
        dbl_mode    = 1'b0;
        dead_cycles = 8'd2;
        repeat (5) @(negedge clk);
        check(gate_on == 6'b0, "R8 reset gates", int'(gate_on), 0);
        check(peak_strobe == 1'b0, "R6 reset peak", int'(peak_strobe), 0);
        rst = 1'b0;

        // R8 / R6: start-up timing counted in edges since release
        nz = 0;
        first_pk = 0;
        for (int k = 1; k <= 3 * TOP + 2; k++) begin
            @(negedge clk);
            if (k < 3 * TOP + 2 && gate_on != 6'b0) nz++;
            if (peak_strobe && first_pk == 0) first_pk = k;
        end
        check(nz == 0, "R8 gates low before drive", nz, 0);
        check(gate_on == 6'b100101, "R8 first gate pattern", int'(gate_on), 37);
        check(first_pk == TOP, "R6 first peak", first_pk, TOP);

        wait_peak();
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!peak_strobe);
        check(n == PER, "R6 carrier period", n, PER);

        // table walk: on-counts, exclusivity (R3) and lockstep per vector
        for (int v = 0; v < NV; v++) begin
            int  cnt [6];
            int  bad_x;
            int  bad_l;
            bit  pos;
            dbl_mode    = VEC[v][0][0];
            ref_sample  = 16'(VEC[v][1]);
            dead_cycles = 8'(VEC[v][2]);
            pos         = (VEC[v][1] >= 0);
            repeat (3) wait_peak();
            for (int i = 0; i < 6; i++) cnt[i] = 0;
            bad_x = 0;
            bad_l = 0;
            for (int c = 0; c < PER; c++) begin
                @(negedge clk);
                for (int i = 0; i < 6; i++) cnt[i] += int'(gate_on[i]);
                if ((gate_on[0] && gate_on[1]) || (gate_on[2] && gate_on[3])) bad_x++;
                if (pos && (gate_on[4] != gate_on[3] || gate_on[5] != gate_on[0])) bad_l++;
                if (!pos && (gate_on[4] != gate_on[1] || gate_on[5] != gate_on[2])) bad_l++;
            end
            for (int i = 0; i < 6; i++)
                check(cnt[i] == VEC[v][3 + i], TAGS[v], cnt[i], VEC[v][3 + i]);
            check(bad_x == 0, "R3 overlap", bad_x, 0);
            check(bad_l == 0, TAGS[v], bad_l, 0);
        end

        // R7: a mid-period change of reference and mode waits for the next peak
        dbl_mode    = 1'b0;
        ref_sample  = 16'sd8;
        dead_cycles = 8'd2;
        repeat (3) wait_peak();
        wait_peak();
        @(posedge clk);
        #1;
        ref_sample = -16'sd12;
        dbl_mode   = 1'b1;
        ok = 1'b1;
        for (int c = 0; c < 15; c++) begin
            @(negedge clk);
            if (!(gate_on[0] && !gate_on[1])) ok = 1'b0;
        end
        check(ok, "R7 no change before peak", int'(ok), 1);
        wait_peak();
        repeat (6) @(negedge clk);
        check(gate_on[1] && !gate_on[0], "R7 change after peak", int'(gate_on[1:0]), 2);

        // R8: reset during operation drops all gates
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(gate_on == 6'b0, "R8 reset mid-run", int'(gate_on), 0);
        rst = 1'b0;

        finish_run();
    end
endmodule